// File: doc/BRIEF.md
# Packet Slot Allocator

This block manages a pool of packet buffer slots for a network controller. A host asks for a slot by pulsing an allocate command. The block does not answer at once. Two cycles later it picks the lowest-numbered slot that is still free and writes the outcome into a result word. It then raises a done flag, which the host polls and clears by writing one.

The result word holds the granted slot number and a failure flag. The flag is the most significant bit, so when an allocation succeeds the whole word equals the slot number and can be handed on without masking. When no slot is free, the flag is set and the number field is zero.

Slots come back to the pool through a release port. The block also reports how many slots are free at any moment.

Top module: `pkt_slot_alloc`

## Requirements
- R1: After reset, all 32 slots are free, `free_count` reads 32, `alloc_done` is 0 and `result_word` is 0.
- R2: An allocate command that is accepted at rising edge N makes `alloc_done` read 1 after edge N+2, and not before.
- R3: An allocation grants the lowest-numbered free slot. That slot leaves the pool, and `free_count` drops by one at the completion edge.
- R4: `result_word` bit 5 is the failure flag and bits 4:0 are the slot number. On success bit 5 is 0, so the word equals the slot number.
- R5: With no free slot, an allocation still sets `alloc_done`. It writes failure flag 1 with number field 0, and `free_count` stays 0.
- R6: `alloc_done` stays at 1 until `done_ack` is sampled high. If a completion falls on the same edge as `done_ack`, `alloc_done` stays 1.
- R7: An allocate command sampled while a request is pending is ignored: it causes no extra completion and takes no extra slot. A request is pending from the accepting edge through its completion edge.
- R8: A release of an allocated slot returns it to the pool. `free_count` rises by one after the sampling edge, and the slot can be granted again.
- R9: A release of a slot that is already free is ignored, and `free_count` is unchanged.
- R10: `result_word` keeps the outcome of the most recent completed allocation until the next completion, including after `done_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Allocate command strobe |
| done_ack | input | 1 | Write-one-to-clear strobe for `alloc_done` |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 5 | Slot number being released |
| result_word | output | 6 | {failure flag, slot number} of the latest allocation |
| alloc_done | output | 1 | Allocation-complete status, sticky |
| free_count | output | 6 | Number of free slots |

## Verification
A corrupted free bitmap shows up at the ports on the next clock edge. It appears as a `free_count` that differs from the count of grants and releases so far, or as a slot number that is not the lowest free one at the next completion. A sequencer stuck in a wait state, or one that restarts while busy, shows as `alloc_done` rising one cycle early, one cycle late, or not at all. An extra slot taken by an ignored command lowers `free_count` within three edges. The bench checks each completion on its exact cycle. It also checks the count after every grant and release, so a fault appears within a few cycles of the stimulus that exposes it.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pa_seq.sv
module pa_seq
  import pa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic accept,
  output logic fin
);
  seq_state_e state_q, state_d;

  assign accept = req && (state_q == SEQ_IDLE);
  assign fin    = (state_q == SEQ_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (req) state_d = SEQ_WAIT;
      SEQ_WAIT: state_d = SEQ_FIN;
      SEQ_FIN:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R2: completion exactly two edges after acceptance
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 fin);
  // R7: every completion traces back to exactly one accepted command
  assert_fin_has_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(accept, 2));
endmodule

// File: rtl/pa_lowest.sv
module pa_lowest #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pa_popcount.sv
module pa_popcount #(
  parameter int N     = 32,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CNT_W'(vec[i]);
  end
endmodule

// File: rtl/pa_free_map.sv
module pa_free_map #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_en,
  input  logic [IDX_W-1:0] grant_idx,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx,
  output logic [N-1:0]     free_map
);
  logic [N-1:0] map_q, map_d;
  logic         rel_ok;

  assign rel_ok   = rel_en && !map_q[rel_idx];
  assign free_map = map_q;

  always_comb begin
    map_d = map_q;
    if (grant_en) map_d[grant_idx] = 1'b0;
    if (rel_ok)   map_d[rel_idx]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '1;
    else        map_q <= map_d;
  end

  // R3: a granted slot must be free when granted, and gone afterwards
  assert_grant_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |-> map_q[grant_idx]);
  assert_grant_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |=> !map_q[$past(grant_idx)]);
  // R8: releasing an allocated slot frees it
  assert_release_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !map_q[rel_idx]) |=> map_q[$past(rel_idx)]);
endmodule

// File: rtl/pkt_slot_alloc.sv
module pkt_slot_alloc #(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int WORD_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              done_ack,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_slot,
  output logic [WORD_W-1:0] result_word,
  output logic              alloc_done,
  output logic [CNT_W-1:0]  free_count
);
  logic [1:0]           rst_sync_q;
  logic                 rst_i_n;
  logic                 accept, fin, found, grant_en;
  logic [IDX_W-1:0]     low_idx;
  logic [NUM_SLOTS-1:0] free_map;
  logic [WORD_W-1:0]    word_q, word_d;
  logic                 done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  pa_seq i_seq (
    .clk(clk), .rst_n(rst_i_n), .req(alloc_req), .accept(accept), .fin(fin)
  );

  pa_lowest #(.N(NUM_SLOTS), .IDX_W(IDX_W)) i_lowest (
    .vec(free_map), .found(found), .idx(low_idx)
  );

  assign grant_en = fin && found;

  pa_free_map #(.N(NUM_SLOTS), .IDX_W(IDX_W)) i_map (
    .clk(clk), .rst_n(rst_i_n), .grant_en(grant_en), .grant_idx(low_idx),
    .rel_en(rel_valid), .rel_idx(rel_slot), .free_map(free_map)
  );

  pa_popcount #(.N(NUM_SLOTS), .CNT_W(CNT_W)) i_pop (
    .vec(free_map), .cnt(free_count)
  );

  always_comb begin
    word_d = word_q;
    done_d = done_q;
    if (done_ack) done_d = 1'b0;
    if (fin) begin
      done_d = 1'b1;
      word_d = found ? {1'b0, low_idx} : {1'b1, {IDX_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      word_q <= word_d;
      done_q <= done_d;
    end
  end

  assign result_word = word_q;
  assign alloc_done  = done_q;

  // R5: a failed result carries a zero number field
  assert_fail_zero_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    result_word[IDX_W] |-> (result_word[IDX_W-1:0] == '0));
  // R6: done is sticky without an acknowledge
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (alloc_done && !done_ack) |=> alloc_done);
  // R10: the result only moves on a completion
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !fin |=> $stable(result_word));
endmodule

// File: tb/test_pkt_slot_alloc.sv
`timescale 1ns/1ps
module test_pkt_slot_alloc;
  logic       clk = 1'b0;
  logic       rst_n, alloc_req, done_ack, rel_valid;
  logic [4:0] rel_slot;
  logic [5:0] result_word, free_count;
  logic       alloc_done;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  pkt_slot_alloc i_pkt_slot_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .done_ack(done_ack),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .result_word(result_word),
    .alloc_done(alloc_done), .free_count(free_count)
  );

  // {op: 0 alloc / 1 release, slot, expected word, expected free count}
  localparam logic [17:0] VEC [0:8] = '{
    {1'b0, 5'd0, 6'd0, 6'd31},
    {1'b0, 5'd0, 6'd1, 6'd30},
    {1'b0, 5'd0, 6'd2, 6'd29},
    {1'b1, 5'd1, 6'd0, 6'd30},
    {1'b0, 5'd0, 6'd1, 6'd29},
    {1'b1, 5'd1, 6'd0, 6'd30},
    {1'b1, 5'd1, 6'd0, 6'd30},
    {1'b1, 5'd5, 6'd0, 6'd30},
    {1'b0, 5'd0, 6'd1, 6'd29}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ack_done();
    done_ack = 1'b1;
    @(negedge clk) done_ack = 1'b0;
    chk("R6 cleared by ack", alloc_done, 0);
  endtask

  task automatic alloc_check(input int exp_word, input int exp_cnt);
    @(negedge clk) alloc_req = 1'b1;
    @(negedge clk) alloc_req = 1'b0;
    chk("R2 not done after N", alloc_done, 0);
    @(negedge clk) chk("R2 not done after N+1", alloc_done, 0);
    @(negedge clk) chk("R2 done after N+2", alloc_done, 1);
    chk("R3/R4 result word", result_word, exp_word);
    chk("R3 free count", free_count, exp_cnt);
    ack_done();
    chk("R10 word kept after ack", result_word, exp_word);
  endtask

  task automatic release_check(input int slot, input int exp_cnt);
    @(negedge clk) begin rel_valid = 1'b1; rel_slot = 5'(slot); end
    @(negedge clk) rel_valid = 1'b0;
    chk("R8/R9 free count after release", free_count, exp_cnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; alloc_req = 1'b0; done_ack = 1'b0; rel_valid = 1'b0; rel_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 free count", free_count, 32);
    chk("R1 done", alloc_done, 0);
    chk("R1 word", result_word, 0);

    for (int v = 0; v < 9; v++) begin
      if (VEC[v][17]) release_check(int'(VEC[v][16:12]), int'(VEC[v][5:0]));
      else            alloc_check(int'(VEC[v][11:6]), int'(VEC[v][5:0]));
    end

    // exhaust the pool, lowest first (R3)
    for (int s = 3; s < 32; s++) alloc_check(s, 31 - s);

    // R5: empty pool
    alloc_check(32, 0);
    chk("R5 number field zero", result_word[4:0], 0);

    // R7: command held through a busy request
    release_check(7, 1);
    release_check(9, 2);
    @(negedge clk) alloc_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk) alloc_req = 1'b0;
    chk("R7 single completion done", alloc_done, 1);
    chk("R7 granted lowest", result_word, 7);
    ack_done();
    repeat (4) @(negedge clk);
    chk("R7 no extra completion", alloc_done, 0);
    chk("R7 no extra slot taken", free_count, 1);

    // R6: ack on the completion edge loses
    @(negedge clk) alloc_req = 1'b1;
    @(negedge clk) alloc_req = 1'b0;
    @(negedge clk) done_ack = 1'b1;
    @(negedge clk) done_ack = 1'b0;
    chk("R6 completion beats ack", alloc_done, 1);
    chk("R10 latest result", result_word, 9);
    chk("R3 count after last grant", free_count, 0);
    repeat (5) @(negedge clk);
    chk("R6 done sticky", alloc_done, 1);
    ack_done();
    chk("R10 word held", result_word, 9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule